// File: doc/BRIEF.md
# In-flight destination hazard scoreboard

This block keeps a short record of the destination registers belonging to instructions that have passed decode and have not yet written back. Decode places the register index of each instruction it accepts into the block. The index may be absent when the instruction writes no register. In the same cycle, decode presents the two source indices and the destination index of the next candidate instruction. Any reported match stalls that candidate, so read-after-write and write-after-write hazards are both caught.

Entries are kept in a circular buffer and leave strictly in arrival order. Writeback retires the oldest entry in the cycle it writes the register file. A search made in that same cycle already treats the retiring entry as gone. An entry inserted in a cycle is searchable only from the following cycle. The depth defaults to two in-flight instructions. Register 0 takes part in matching unless a parameter turns that off.

Top module: `hzd_scoreboard`

## Requirements
- R1: After reset, the block is empty: `empty_o`=1 and `full_o`=0, and every search port reports no match.
- R2: An insert with `ins_valid_i`=1 records the index on `ins_dst_*`. A search first sees this entry in the cycle after the insert, never in the insert cycle itself.
- R3: There are three independent search ports (source 1, source 2, destination). Each port reports a hit when its valid key equals the index of any valid, live entry. The results of the three ports do not depend on one another.
- R4: An index that is absent never matches. This holds for an entry stored with its valid flag at 0, and for a search key whose valid flag is 0, whatever the index bits are.
- R5: Each remove (`rem_i`=1) retires the single oldest entry. Entries retire in insertion order.
- R6: In a cycle with `rem_i`=1, the entry being retired produces no hit on any search port. All other live entries still match.
- R7: `full_o`=1 exactly when DEPTH entries are held. `empty_o`=1 exactly when no entries are held. Both flags are registered state and change only on the cycle after an insert or remove.
- R8: When the block is full, an insert together with a remove in the same cycle is accepted. The block then stays full, with the new entry youngest. An insert while full without a remove, or a remove while empty, is illegal and is flagged by an assertion.
- R9: With ZERO_MATCH=1 (the default), register index 0 matches like any other index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Insert an entry this cycle |
| ins_dst_valid_i | input | 1 | Inserted instruction writes a register |
| ins_dst_idx_i | input | 5 | Destination index of the inserted instruction |
| rem_i | input | 1 | Retire the oldest entry this cycle |
| src1_valid_i | input | 1 | Source 1 key present |
| src1_idx_i | input | 5 | Source 1 key index |
| src2_valid_i | input | 1 | Source 2 key present |
| src2_idx_i | input | 5 | Source 2 key index |
| dst_valid_i | input | 1 | Destination key present |
| dst_idx_i | input | 5 | Destination key index |
| hit_src1_o | output | 1 | Source 1 matches a live entry |
| hit_src2_o | output | 1 | Source 2 matches a live entry |
| hit_dst_o | output | 1 | Destination matches a live entry |
| full_o | output | 1 | DEPTH entries held |
| empty_o | output | 1 | No entries held |

## Verification
Some behaviours are checked by the assertions on every cycle. These are: an absent key never hits, no port hits when nothing is live, the flags step correctly when the buffer fills or drains, and no overflow or underflow occurs. Other behaviours can only be shown by the bench's scenarios, which compare against a queue model. These are: retirement in arrival order, the retiring entry disappearing from same-cycle searches, an insert being invisible in its own cycle, stored absent entries never matching, and the full-plus-remove replacement case.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  parameter int unsigned REG_IDX_W = 5;

  typedef struct packed {
    logic                 valid;
    logic [REG_IDX_W-1:0] idx;
  } reg_tag_t;
endpackage

// File: rtl/hzd_ring.sv
module hzd_ring
  import hzd_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  reg_tag_t push_ent_i,
  input  logic     pop_i,
  output reg_tag_t ent_o [DEPTH],
  output logic [DEPTH-1:0] live_o,
  output logic     full_o,
  output logic     empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(DEPTH);

  reg_tag_t         mem_q [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= ptr_inc(tail_q);
      if (pop_i)  head_q <= ptr_inc(head_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (push_i && (tail_q == PTR_W'(g))) begin
        mem_q[g] <= push_ent_i;
      end
    end
    assign ent_o[g] = mem_q[g];
  end

  // slot live if occupied and not being retired this cycle
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int  off;
      logic occ;
      off = (i + int'(DEPTH) - int'(head_q)) % int'(DEPTH);
      occ = off < int'(cnt_q);
      live_o[i] = occ && !(pop_i && (head_q == PTR_W'(i)));
    end
  end

  assign full_o  = (cnt_q == MAX_CNT);
  assign empty_o = (cnt_q == '0);

  p_no_underflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |-> pop_i);
  p_fill_sets_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX_CNT - 1'b1 && push_i && !pop_i) |=> full_o);
  p_drain_sets_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(1) && pop_i && !push_i) |=> empty_o);
  p_push_leaves_nonempty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> !empty_o);
endmodule

// File: rtl/hzd_match.sv
module hzd_match
  import hzd_pkg::*;
#(
  parameter int unsigned DEPTH      = 2,
  parameter bit          ZERO_MATCH = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 key_valid_i,
  input  logic [REG_IDX_W-1:0] key_idx_i,
  input  reg_tag_t             ent_i [DEPTH],
  input  logic [DEPTH-1:0]     live_i,
  output logic                 hit_o
);
  logic [DEPTH-1:0] eq;
  logic             key_ok;

  assign key_ok = key_valid_i && (ZERO_MATCH || (key_idx_i != '0));

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = live_i[g] && ent_i[g].valid && (ent_i[g].idx == key_idx_i);
  end

  assign hit_o = key_ok && (|eq);

  p_absent_key_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_valid_i |-> !hit_o);
  p_nothing_live_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_i == '0) |-> !hit_o);
endmodule

// File: rtl/hzd_scoreboard.sv
module hzd_scoreboard
  import hzd_pkg::*;
#(
  parameter int unsigned DEPTH      = 2,
  parameter bit          ZERO_MATCH = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ins_valid_i,
  input  logic                 ins_dst_valid_i,
  input  logic [REG_IDX_W-1:0] ins_dst_idx_i,
  input  logic                 rem_i,
  input  logic                 src1_valid_i,
  input  logic [REG_IDX_W-1:0] src1_idx_i,
  input  logic                 src2_valid_i,
  input  logic [REG_IDX_W-1:0] src2_idx_i,
  input  logic                 dst_valid_i,
  input  logic [REG_IDX_W-1:0] dst_idx_i,
  output logic                 hit_src1_o,
  output logic                 hit_src2_o,
  output logic                 hit_dst_o,
  output logic                 full_o,
  output logic                 empty_o
);
  localparam int unsigned N_PORTS = 3;

  reg_tag_t             ents [DEPTH];
  logic [DEPTH-1:0]     live;
  reg_tag_t             new_ent;
  logic                 key_v   [N_PORTS];
  logic [REG_IDX_W-1:0] key_idx [N_PORTS];
  logic [N_PORTS-1:0]   hits;

  assign new_ent.valid = ins_dst_valid_i;
  assign new_ent.idx   = ins_dst_idx_i;

  hzd_ring #(.DEPTH(DEPTH)) u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (ins_valid_i),
    .push_ent_i (new_ent),
    .pop_i      (rem_i),
    .ent_o      (ents),
    .live_o     (live),
    .full_o     (full_o),
    .empty_o    (empty_o)
  );

  assign key_v[0] = src1_valid_i; assign key_idx[0] = src1_idx_i;
  assign key_v[1] = src2_valid_i; assign key_idx[1] = src2_idx_i;
  assign key_v[2] = dst_valid_i;  assign key_idx[2] = dst_idx_i;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    hzd_match #(.DEPTH(DEPTH), .ZERO_MATCH(ZERO_MATCH)) u_match (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .key_valid_i (key_v[p]),
      .key_idx_i   (key_idx[p]),
      .ent_i       (ents),
      .live_i      (live),
      .hit_o       (hits[p])
    );
  end

  assign hit_src1_o = hits[0];
  assign hit_src2_o = hits[1];
  assign hit_dst_o  = hits[2];

  p_empty_no_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (hits == '0));
  p_flags_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
endmodule

// File: tb/sim_hzd_scoreboard.sv
`timescale 1ns/100ps
module sim_hzd_scoreboard;
  localparam int DEPTH = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ins_valid, ins_dst_valid, rem;
  logic [4:0] ins_dst_idx;
  logic s1v, s2v, dv;
  logic [4:0] s1, s2, d;
  logic h1, h2, hd, full, empty;

  always #2.5 clk = ~clk;

  hzd_scoreboard #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .ins_valid_i(ins_valid), .ins_dst_valid_i(ins_dst_valid), .ins_dst_idx_i(ins_dst_idx),
    .rem_i(rem),
    .src1_valid_i(s1v), .src1_idx_i(s1),
    .src2_valid_i(s2v), .src2_idx_i(s2),
    .dst_valid_i(dv), .dst_idx_i(d),
    .hit_src1_o(h1), .hit_src2_o(h2), .hit_dst_o(hd),
    .full_o(full), .empty_o(empty)
  );

  typedef struct { bit v; bit [4:0] idx; } ent_t;
  typedef struct { string tag; bit e1; bit e2; bit ed; bit ef; bit ee; } exp_t;

  ent_t mq[$];
  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  function automatic bit model_hit(bit kv, bit [4:0] k, bit r);
    if (!kv) return 1'b0;
    for (int j = (r ? 1 : 0); j < mq.size(); j++)
      if (mq[j].v && mq[j].idx == k) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string tag, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected results and compares mid-cycle
  always begin
    @(negedge clk);
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, "hit_src1", h1, e.e1);
      chk(e.tag, "hit_src2", h2, e.e2);
      chk(e.tag, "hit_dst", hd, e.ed);
      chk(e.tag, "full", full, e.ef);
      chk(e.tag, "empty", empty, e.ee);
    end
  end

  task automatic step(string tag, bit ins, bit insv, bit [4:0] insi, bit r,
                      bit a_v, bit [4:0] a, bit b_v, bit [4:0] b, bit c_v, bit [4:0] c);
    exp_t e;
    @(negedge clk);
    ins_valid = ins; ins_dst_valid = insv; ins_dst_idx = insi; rem = r;
    s1v = a_v; s1 = a; s2v = b_v; s2 = b; dv = c_v; d = c;
    e.tag = tag;
    e.e1 = model_hit(a_v, a, r);
    e.e2 = model_hit(b_v, b, r);
    e.ed = model_hit(c_v, c, r);
    e.ef = (mq.size() == DEPTH);
    e.ee = (mq.size() == 0);
    exp_q.push_back(e);
    @(posedge clk);
    if (r) void'(mq.pop_front());
    if (ins) begin
      ent_t n;
      n.v = insv; n.idx = insi;
      mq.push_back(n);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    ins_valid = 0; ins_dst_valid = 0; ins_dst_idx = 0; rem = 0;
    s1v = 0; s1 = 0; s2v = 0; s2 = 0; dv = 0; d = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1: cleared state, searches see nothing
    step("R1", 0,0,0, 0, 1,3, 1,0, 1,31);
    // R2: insert 7, same-cycle search must not see it
    step("R2", 1,1,7, 0, 1,7, 1,7, 1,7);
    // R2/R3: visible next cycle on every port; other index misses
    step("R2", 0,0,0, 0, 1,7, 1,7, 1,7);
    step("R3", 0,0,0, 0, 1,8, 1,7, 0,7);
    // R4: insert absent destination with index bits 0 -> fills (R7)
    step("R4", 1,0,0, 0, 0,7, 1,0, 1,0);
    step("R4", 0,0,0, 0, 0,7, 1,0, 1,0);
    step("R7", 0,0,0, 0, 1,7, 1,1, 1,0);
    // R8/R6: full, remove + insert 9; retiring 7 not seen
    step("R6", 1,1,9, 1, 1,7, 1,9, 1,7);
    // R5: oldest (7) gone, absent entry and 9 remain, still full
    step("R5", 0,0,0, 0, 1,7, 1,9, 1,0);
    step("R8", 0,0,0, 0, 1,9, 0,9, 1,9);
    // R5: remove retires the absent entry, 9 stays live
    step("R5", 0,0,0, 1, 1,9, 1,9, 1,7);
    step("R5", 0,0,0, 0, 1,9, 1,4, 1,9);
    // R6: last entry retiring, drains to empty (R7)
    step("R6", 0,0,0, 1, 1,9, 1,9, 1,9);
    step("R7", 0,0,0, 0, 1,9, 1,9, 1,9);
    // R9: register 0 matches; R3 with two entries 4 and 0
    step("R9", 1,1,0, 0, 0,0, 0,0, 0,0);
    step("R9", 1,1,4, 0, 1,0, 1,5, 1,0);
    step("R3", 0,0,0, 0, 1,4, 1,0, 1,6);
    step("R3", 0,0,0, 0, 1,6, 1,5, 1,4);
    // R6 with two live: retiring 0, 4 still matches
    step("R6", 0,0,0, 1, 1,0, 1,4, 1,0);
    step("R5", 0,0,0, 1, 1,4, 1,0, 1,4);
    step("R7", 0,0,0, 0, 1,4, 1,0, 1,4);

    @(negedge clk);
    #2;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule